// File: doc/BRIEF.md
# Cascadable Up/Down Counter Stage

This block is one slice of a synchronous binary counter that can step in either direction. All count bits move together on the rising clock edge whenever the active-low count enable was low during the preceding low phase of the clock. A direction input chooses between incrementing and decrementing. An active-low preset copies a parallel value onto the count as soon as it goes low, with no clock edge needed, and it overrides counting for as long as it stays low.

Two outputs let slices be joined into wider counters. The terminal flag is high while the slice sits at the last value of its current direction. The active-low carry pulse drops only during the low half of the clock, and only while the slice is both at its terminal value and enabled. When every slice shares one clock, each slice's carry pulse feeds the count enable of the next slice up, and the chain behaves as a single wide up/down counter. Reloading the preset each time the terminal value is reached shortens the cycle, so the slice can divide by N.

Top module: `updn_cnt_stage`

## Requirements
- R1: The count changes only on a rising clock edge, and only if `cnt_en_n` was low during the low clock phase just before that edge. With `cnt_en_n` high the count holds its value. `cnt_en_n` is expected to change only while the clock is high.
- R2: With `dir_down` = 0, an enabled edge adds one to the count.
- R3: With `dir_down` = 1, an enabled edge subtracts one from the count.
- R4: Counting up from all ones gives zero. Counting down from zero gives all ones.
- R5: While `preset_n` is low, `count` equals `preset_val` at once, with no clock edge needed, and clock edges do not change it. After `preset_n` goes high, counting resumes from the loaded value. `preset_val` must stay stable until `preset_n` has been high for a moment.
- R6: `term_flag` is 1 exactly when the count is all ones with `dir_down` = 0, or zero with `dir_down` = 1. It follows a change of direction with no clock edge.
- R7: `carry_pulse_n` is 0 only while `clk` is low, `term_flag` is 1 and `cnt_en_n` is 0. In every other case it is 1.
- R8: Two stages share one clock, with the upper stage's `cnt_en_n` driven by the lower stage's `carry_pulse_n`. The pair then counts as one 8-bit up/down counter, with `{upper count, lower count}` as the value.
- R9: If the preset is pulsed each time `term_flag` rises, the count repeats the cycle from the preset value to the terminal value. For example, loading 12 while counting up gives the repeating sequence 12, 13, 14, 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock; rising edge advances the count |
| cnt_en_n | input | 1 | Active-low count enable, sampled through the low clock phase |
| dir_down | input | 1 | 0 counts up, 1 counts down |
| preset_n | input | 1 | Active-low asynchronous parallel load |
| preset_val | input | WIDTH | Value copied onto the count while `preset_n` is low |
| count | output | WIDTH | Current count |
| term_flag | output | 1 | High at all ones (up) or zero (down) |
| carry_pulse_n | output | 1 | Active-low cascade pulse during the low clock phase at terminal count |

## Verification
Two stages are chained on a common clock, and the 8-bit value is compared with a simple integer model. The runs start from values that make the lower nibble cross its boundary, which separates a correct carry into the upper stage from a stage that only wraps locally. Full 8-bit wraps in both directions show whether the lower slice's terminal value ends the count correctly at both ends. Further patterns cover these cases:
- A load that lands during the low clock phase and then spans an edge, which shows that the preset is asynchronous and takes priority.
- A held enable while the slice sits at its terminal value, which separates gating of the carry pulse from gating of the count.
- A change of direction with no clock edge, which shows that the flag is decoded combinationally.
- A repeated reload at terminal count, which checks division by N.

// File: rtl/updn_cnt_pkg.sv
package updn_cnt_pkg;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } cnt_dir_e;

endpackage

// File: rtl/updn_cnt_next.sv
module updn_cnt_next #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             down,
  output logic [WIDTH-1:0] nxt,
  output logic             chain_out
);

  // Each bit flips when every lower bit already sits at its limit:
  // ones when counting up, zeros when counting down.
  logic [WIDTH:0] toggle_chain;

  assign toggle_chain[0] = 1'b1;

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      assign toggle_chain[gi+1] = toggle_chain[gi] & (cur[gi] ^ down);
      assign nxt[gi]            = cur[gi] ^ toggle_chain[gi];
    end
  endgenerate

  // All bits at their limit: the slice would roll over on this step.
  assign chain_out = toggle_chain[WIDTH];

endmodule

// File: rtl/updn_cnt_term.sv
module updn_cnt_term #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             down,
  output logic             term
);

  import updn_cnt_pkg::*;

  function automatic logic at_limit(input logic [WIDTH-1:0] v, input cnt_dir_e d);
    logic [WIDTH-1:0] lim;
    lim = (d == DIR_DOWN) ? '0 : '1;
    return (v == lim);
  endfunction

  assign term = at_limit(cur, cnt_dir_e'(down));

endmodule

// File: rtl/updn_cnt_gate.sv
module updn_cnt_gate (
  input  logic clk,
  input  logic cnt_en_n,
  input  logic term,
  output logic step_go,
  output logic carry_pulse_n
);

  // Enable is captured while the clock is low and frozen through the high
  // phase, so an upstream carry pulse that ends at the rising edge still
  // counts on that edge.
  logic en_n_held;

  always_latch begin
    if (!clk) en_n_held = cnt_en_n;
  end

  assign step_go       = ~en_n_held;
  assign carry_pulse_n = ~(term & ~cnt_en_n & ~clk);

  always_comb begin
    if (carry_pulse_n == 1'b0) begin
      a_r7_pulse_only_low_phase: assert (clk == 1'b0 && term == 1'b1 && cnt_en_n == 1'b0);
    end
  end

endmodule

// File: rtl/updn_cnt_stage.sv
module updn_cnt_stage #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             cnt_en_n,
  input  logic             dir_down,
  input  logic             preset_n,
  input  logic [WIDTH-1:0] preset_val,
  output logic [WIDTH-1:0] count,
  output logic             term_flag,
  output logic             carry_pulse_n
);

  localparam logic [WIDTH-1:0] ALL_ONES = '1;
  localparam logic [WIDTH-1:0] ALL_ZERO = '0;

  logic [WIDTH-1:0] cnt_r;
  logic [WIDTH-1:0] cnt_nxt;
  logic             roll_chain;
  logic             step_go;

  updn_cnt_next #(.WIDTH(WIDTH)) u_next (
    .cur       (count),
    .down      (dir_down),
    .nxt       (cnt_nxt),
    .chain_out (roll_chain)
  );

  updn_cnt_term #(.WIDTH(WIDTH)) u_term (
    .cur  (count),
    .down (dir_down),
    .term (term_flag)
  );

  updn_cnt_gate u_gate (
    .clk           (clk),
    .cnt_en_n      (cnt_en_n),
    .term          (term_flag),
    .step_go       (step_go),
    .carry_pulse_n (carry_pulse_n)
  );

  always_ff @(posedge clk or negedge preset_n) begin
    if (!preset_n)    cnt_r <= preset_val;
    else if (step_go) cnt_r <= cnt_nxt;
  end

  // The preset drives the output straight through while it is held low.
  assign count = preset_n ? cnt_r : preset_val;

  // R6: the ripple chain and the limit decoder are built separately.
  a_r6_term_matches_chain: assert property (@(posedge clk) disable iff (!preset_n)
    roll_chain == term_flag);

  a_r1_hold_when_disabled: assert property (@(posedge clk) disable iff (!preset_n)
    !step_go |=> $stable(count));

  a_r2_step_up: assert property (@(posedge clk) disable iff (!preset_n)
    (step_go && !dir_down) |=> count == WIDTH'($past(count) + 1'b1));

  a_r3_step_down: assert property (@(posedge clk) disable iff (!preset_n)
    (step_go && dir_down) |=> count == WIDTH'($past(count) - 1'b1));

  a_r4_wrap_up: assert property (@(posedge clk) disable iff (!preset_n)
    (step_go && !dir_down && count == ALL_ONES) |=> count == ALL_ZERO);

  a_r4_wrap_down: assert property (@(posedge clk) disable iff (!preset_n)
    (step_go && dir_down && count == ALL_ZERO) |=> count == ALL_ONES);

endmodule

// File: tb/updn_cnt_stage_tb_top.sv
module updn_cnt_stage_tb_top;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       en_n = 1'b1;
  logic       dir_down = 1'b0;
  logic       preset_n = 1'b0;
  logic [7:0] data8 = 8'h00;

  logic [3:0] lo_cnt, hi_cnt;
  logic       lo_term, hi_term, lo_carry, hi_carry;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int model = 0;

  always #(CLK_P/2) clk = ~clk;

  updn_cnt_stage #(.WIDTH(4)) dut_i (
    .clk(clk), .cnt_en_n(en_n), .dir_down(dir_down), .preset_n(preset_n),
    .preset_val(data8[3:0]), .count(lo_cnt), .term_flag(lo_term),
    .carry_pulse_n(lo_carry)
  );

  updn_cnt_stage #(.WIDTH(4)) dut_hi_i (
    .clk(clk), .cnt_en_n(lo_carry), .dir_down(dir_down), .preset_n(preset_n),
    .preset_val(data8[7:4]), .count(hi_cnt), .term_flag(hi_term),
    .carry_pulse_n(hi_carry)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Advance to the next rising edge and settle inside the high phase.
  task automatic go_edge();
    @(posedge clk);
    #4;
  endtask

  task automatic do_load(input int v);
    preset_n = 1'b0;
    data8    = v[7:0];
    go_edge();
    preset_n = 1'b1;
    model    = v;
  endtask

  task automatic t_init();
    do_load(8'h00);
    chk("R5 reset value", {hi_cnt, lo_cnt}, 0);
    chk("R6 zero while up", lo_term, 0);
  endtask

  task automatic t_up_cross();
    dir_down = 1'b0;
    do_load(8'h0E);
    en_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      go_edge();
      model = (model + 1) % 256;
      chk("R2 R8 up across nibble", {hi_cnt, lo_cnt}, model);
    end
  endtask

  task automatic t_wrap_up();
    en_n = 1'b1;
    dir_down = 1'b0;
    do_load(8'hFE);
    en_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      go_edge();
      model = (model + 1) % 256;
      chk("R4 wrap up", {hi_cnt, lo_cnt}, model);
    end
  endtask

  task automatic t_down_cross();
    en_n = 1'b1;
    dir_down = 1'b1;
    do_load(8'h12);
    en_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      go_edge();
      model = (model + 255) % 256;
      chk("R3 R8 down across nibble", {hi_cnt, lo_cnt}, model);
    end
  endtask

  task automatic t_wrap_down();
    en_n = 1'b1;
    dir_down = 1'b1;
    do_load(8'h01);
    en_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      go_edge();
      model = (model + 255) % 256;
      chk("R4 wrap down", {hi_cnt, lo_cnt}, model);
    end
  endtask

  task automatic t_hold();
    en_n = 1'b1;
    dir_down = 1'b0;
    do_load(8'hFF);
    for (int i = 0; i < 3; i++) begin
      go_edge();
      chk("R1 hold", {hi_cnt, lo_cnt}, 8'hFF);
    end
    @(negedge clk); #1;
    chk("R7 no pulse while disabled", lo_carry, 1);
    chk("R6 flag while held", lo_term, 1);
    #4;
  endtask

  task automatic t_ripple();
    en_n = 1'b1;
    dir_down = 1'b0;
    do_load(8'h0F);
    en_n = 1'b0;
    chk("R7 high phase", lo_carry, 1);
    @(negedge clk); #1;
    chk("R7 low phase pulse", lo_carry, 0);
    chk("R7 upper not terminal", hi_carry, 1);
    @(posedge clk); #1;
    chk("R7 pulse ends at edge", lo_carry, 1);
    chk("R8 upper took carry", {hi_cnt, lo_cnt}, 8'h10);
    en_n = 1'b1;
    #3;
  endtask

  task automatic t_dir_flip();
    en_n = 1'b1;
    dir_down = 1'b0;
    do_load(8'h0F);
    chk("R6 at 15 up", lo_term, 1);
    dir_down = 1'b1; #1;
    chk("R6 flag clears on direction", lo_term, 0);
    do_load(8'h00);
    chk("R6 at 0 down", lo_term, 1);
    dir_down = 1'b0; #1;
    chk("R6 flag clears going up", lo_term, 0);
  endtask

  task automatic t_async();
    en_n = 1'b1;
    dir_down = 1'b0;
    do_load(8'h20);
    en_n = 1'b0;
    go_edge();
    @(negedge clk); #1;
    preset_n = 1'b0;
    data8 = 8'h9A;
    #1;
    chk("R5 load without edge", {hi_cnt, lo_cnt}, 8'h9A);
    go_edge();
    chk("R5 load beats edge", {hi_cnt, lo_cnt}, 8'h9A);
    preset_n = 1'b1;
    model = 8'h9A;
    go_edge();
    model++;
    chk("R5 resume after load", {hi_cnt, lo_cnt}, model);
  endtask

  task automatic t_modn();
    int seq[8] = '{13, 14, 15, 12, 13, 14, 15, 12};
    en_n = 1'b1;
    dir_down = 1'b0;
    do_load(8'h0C);
    en_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (lo_term) begin
        @(negedge clk); #1;
        preset_n = 1'b0;
        data8 = 8'h0C;
        go_edge();
        preset_n = 1'b1;
      end else begin
        go_edge();
      end
      chk("R9 modulo-4 cycle", {hi_cnt, lo_cnt}, seq[i]);
    end
    en_n = 1'b1;
  endtask

  initial begin
    #1;
    t_init();
    t_up_cross();
    t_wrap_up();
    t_down_cross();
    t_wrap_down();
    t_hold();
    t_ripple();
    t_dir_flip();
    t_async();
    t_modn();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule